// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block gathers the three interrupt causes of a small 8-bit microcontroller core and presents them to the control unit as one request line. The three causes are a timer overflow pulse, a rising edge on an external interrupt pin, and any change on the four upper bits of an input port. Each cause has its own latched flag and its own enable. One global enable gates all of them. The CPU reads and writes the flags and enables as a single 8-bit control word over a simple register bus.

When the control unit accepts a request it strobes an acknowledge. The block then clears the global enable and, on the next cycle, presents the fixed vector address with a load strobe for the program counter. Flags are left untouched; software clears them before it sets the global enable again. A return strobe sets the global enable. While the core sleeps, any flagged and enabled cause raises a wake signal, whatever the state of the global enable.

The port-change cause compares the live port bits with a snapshot. The snapshot is refreshed each time the CPU reads the port.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: The control word has this layout: bit 7 global enable, bit 5 timer enable, bit 4 external enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external flag, bit 0 port-change flag. Bit 6 always reads 0. After reset the whole word is 0x00.
- R2: A one-cycle high on `tmr_ovf` sets bit 2 at the next clock edge.
- R3: The external pin passes through a two-stage synchronizer and an edge register. A low-to-high transition sets bit 1 three clock edges after the pin changes. A pin that stays high, or falls, sets nothing.
- R4: Bit 0 is set at each clock edge where `port_hi` differs from the snapshot. A high `port_rd` loads the snapshot from `port_hi` at that edge, after which equal values set nothing.
- R5: `irq_req` is high exactly when the global enable is set and at least one cause has both its flag and its enable set.
- R6: An `irq_ack` clears the global enable at the next edge and leaves every flag and enable bit unchanged.
- R7: An `irq_ack` while `irq_req` is high makes `pc_load` high for one cycle after the next edge, with `pc_vector` equal to 0x0004. At all other times `pc_vector` is 0.
- R8: An `irq_ret` sets the global enable at the next edge. If `irq_ack` is high in the same cycle, the acknowledge wins and the global enable ends cleared.
- R9: A register write stores bits 7 and 5..0. A hardware set of a flag in the same cycle as a software write of 0 to that flag leaves the flag set.
- R10: `wake` is high exactly when `in_sleep` is high and some cause has both its flag and its enable set, whatever the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| port_hi | input | 4 | Upper port bits watched for change |
| port_rd | input | 1 | CPU read of the port; refreshes the snapshot |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| irq_ack | input | 1 | Control unit accepts the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| in_sleep | input | 1 | Core is in sleep |
| irq_req | output | 1 | Interrupt request to the control unit |
| wake | output | 1 | Wake request during sleep |
| pc_load | output | 1 | Load the program counter with the vector |
| pc_vector | output | 16 | Vector address, 0x0004 while pc_load is high |

## Verification
A wrong flag or enable shows at once on `reg_rdata`. Within the same cycle it also changes `irq_req` or `wake`, so each check reads the word and the two request lines together. Errors in the synchronizer depth or the snapshot logic show up as a flag that appears one edge early or late, or as a flag that sets again after software clears it. The bench therefore samples the flag on both sides of the expected edge. A lost acknowledge shows up as a global enable that stays set, or as a `pc_load` missing in the cycle after the acknowledge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int NUM_SRC   = 3;
   localparam int CTRL_W    = 8;
   localparam int FLAG_LSB  = 0;
   localparam int EN_LSB    = 3;
   localparam int GIE_BIT   = 7;
   localparam int PAD_BIT   = 6;

   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_TMR  = 2'd2
   } src_idx_e;

   typedef logic [NUM_SRC-1:0] src_vec_t;

   typedef struct packed {
      logic     gie;
      logic     pad;
      src_vec_t en;
      src_vec_t flag;
   } ctrl_word_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int STAGES = 2,
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic edge_hit
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad
         $error("irq_edge_sync needs at least two stages");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
   end

   generate
      if (RISING) begin : g_rise
         assign edge_hit = chain[STAGES-1] & ~last;
      end else begin : g_fall
         assign edge_hit = ~chain[STAGES-1] & last;
      end
   endgenerate
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] port,
   input  logic         rd,
   output logic         changed
);
   logic [W-1:0] snap;

   generate
      if (W < 1) begin : g_bad
         $error("irq_port_watch width must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  snap <= '0;
      else if (rd) snap <= port;
   end

   assign changed = |(port ^ snap);
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
   import irq_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   input  src_vec_t          hw_set,
   input  logic              ack,
   input  logic              ret,
   output logic [CTRL_W-1:0] rdata,
   output logic              gie,
   output logic              pending
);
   src_vec_t   flag_q;
   src_vec_t   en_q;
   logic       gie_q;
   ctrl_word_t word;
   logic       unused_pad;

   assign unused_pad = wdata[PAD_BIT];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q[gi] <= 1'b0;
               en_q[gi]   <= 1'b0;
            end else begin
               flag_q[gi] <= (wr_en ? wdata[FLAG_LSB+gi] : flag_q[gi]) | hw_set[gi];
               if (wr_en) en_q[gi] <= wdata[EN_LSB+gi];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     gie_q <= 1'b0;
      else if (ack)   gie_q <= 1'b0;
      else if (ret)   gie_q <= 1'b1;
      else if (wr_en) gie_q <= wdata[GIE_BIT];
   end

   always_comb begin
      word      = '0;
      word.gie  = gie_q;
      word.pad  = 1'b0;
      word.en   = en_q;
      word.flag = flag_q;
   end

   assign rdata   = word;
   assign gie     = gie_q;
   assign pending = |(flag_q & en_q);
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int          PORT_W      = 4,
   parameter int          SYNC_STAGES = 2,
   parameter bit          EXT_RISING  = 1'b1,
   parameter int          VEC_W       = 16,
   parameter logic [15:0] VECTOR_ADDR = 16'h0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic              tmr_ovf,
   input  logic [PORT_W-1:0] port_hi,
   input  logic              port_rd,
   input  logic              reg_wr_en,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              irq_ack,
   input  logic              irq_ret,
   input  logic              in_sleep,
   output logic              irq_req,
   output logic              wake,
   output logic              pc_load,
   output logic [VEC_W-1:0]  pc_vector
);
   localparam logic [VEC_W-1:0] VEC = VEC_W'(VECTOR_ADDR);

   generate
      if (VEC_W < 3 || VEC_W > 16) begin : g_bad_vec
         $error("mcu_irq_ctrl vector width out of range");
      end
      if (CTRL_W != 8) begin : g_bad_word
         $error("mcu_irq_ctrl control word must be 8 bits");
      end
   endgenerate

   logic     ext_hit;
   logic     port_chg;
   src_vec_t hw_set;
   logic     gie;
   logic     pending;
   logic     load_q;

   irq_edge_sync #(.STAGES(SYNC_STAGES), .RISING(EXT_RISING)) u_ext (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin), .edge_hit(ext_hit)
   );

   irq_port_watch #(.W(PORT_W)) u_port (
      .clk(clk), .rst_n(rst_n), .port(port_hi), .rd(port_rd), .changed(port_chg)
   );

   always_comb begin
      hw_set           = '0;
      hw_set[SRC_PORT] = port_chg;
      hw_set[SRC_EXT]  = ext_hit;
      hw_set[SRC_TMR]  = tmr_ovf;
   end

   irq_ctl_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
      .hw_set(hw_set), .ack(irq_ack), .ret(irq_ret),
      .rdata(reg_rdata), .gie(gie), .pending(pending)
   );

   assign irq_req = gie & pending;
   assign wake    = in_sleep & pending;

   always_ff @(posedge clk) begin
      if (!rst_n) load_q <= 1'b0;
      else        load_q <= irq_ack & irq_req;
   end

   assign pc_load   = load_q;
   assign pc_vector = load_q ? VEC : '0;
endmodule

// File: rtl/mcu_irq_ctrl_chk.sv
module mcu_irq_ctrl_chk #(
   parameter int          VEC_W       = 16,
   parameter logic [15:0] VECTOR_ADDR = 16'h0004
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmr_ovf,
   input logic             reg_wr_en,
   input logic [7:0]       reg_rdata,
   input logic             irq_ack,
   input logic             irq_ret,
   input logic             in_sleep,
   input logic             irq_req,
   input logic             wake,
   input logic             pc_load,
   input logic [VEC_W-1:0] pc_vector
);
   p_tmr_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |=> reg_rdata[2]);

   p_req_needs_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> reg_rdata[7]);

   p_ack_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !reg_rdata[7]);

   p_ack_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !reg_wr_en) |=> (reg_rdata[5:0] == $past(reg_rdata[5:0]) | reg_rdata[5:0]));

   p_vector_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> (pc_load && pc_vector == VEC_W'(VECTOR_ADDR)));

   p_vector_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_load |-> (pc_vector == '0));

   p_ret_sets_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack) |=> reg_rdata[7]);

   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[2] && !reg_wr_en) |=> reg_rdata[2]);

   p_wake_in_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> in_sleep);
endmodule

bind mcu_irq_ctrl mcu_irq_ctrl_chk #(.VEC_W(VEC_W), .VECTOR_ADDR(VECTOR_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .reg_wr_en(reg_wr_en),
   .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
   .in_sleep(in_sleep), .irq_req(irq_req), .wake(wake),
   .pc_load(pc_load), .pc_vector(pc_vector)
);

// File: tb/mcu_irq_ctrl_test.sv
module mcu_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_pin = 1'b0;
   logic        tmr_ovf = 1'b0;
   logic [3:0]  port_hi = 4'h0;
   logic        port_rd = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic        in_sleep = 1'b0;
   logic        irq_req;
   logic        wake;
   logic        pc_load;
   logic [15:0] pc_vector;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   mcu_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
      .port_hi(port_hi), .port_rd(port_rd), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
      .irq_ret(irq_ret), .in_sleep(in_sleep), .irq_req(irq_req), .wake(wake),
      .pc_load(pc_load), .pc_vector(pc_vector)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      reg_wr_en = 1'b1; reg_wdata = d;
      step(1);
      reg_wr_en = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 reset word", {8'h0, reg_rdata}, 16'h0000);
      check("R5 reset req", {15'h0, irq_req}, 16'h0);
      check("R7 reset pc_load", {15'h0, pc_load}, 16'h0);
      wr(8'hFF);
      check("R1 bit6 reads 0", {8'h0, reg_rdata}, 16'h00BF);
      wr(8'h00);
      check("R1 cleared", {8'h0, reg_rdata}, 16'h0000);
   endtask

   task automatic t_timer;
      tmr_ovf = 1'b1;
      step(1);
      tmr_ovf = 1'b0;
      check("R2 timer flag", {8'h0, reg_rdata}, 16'h0004);
      tmr_ovf = 1'b1; reg_wr_en = 1'b1; reg_wdata = 8'h00;
      step(1);
      tmr_ovf = 1'b0; reg_wr_en = 1'b0;
      check("R9 hw set beats sw clear", {8'h0, reg_rdata}, 16'h0004);
      wr(8'h00);
      check("R9 sw clear alone", {8'h0, reg_rdata}, 16'h0000);
   endtask

   task automatic t_ext;
      ext_pin = 1'b1;
      step(2);
      check("R3 flag not yet after two edges", {15'h0, reg_rdata[1]}, 16'h0);
      step(1);
      check("R3 flag after three edges", {15'h0, reg_rdata[1]}, 16'h1);
      wr(8'h00);
      step(4);
      check("R3 steady high sets nothing", {15'h0, reg_rdata[1]}, 16'h0);
      ext_pin = 1'b0;
      step(5);
      check("R3 falling edge sets nothing", {15'h0, reg_rdata[1]}, 16'h0);
   endtask

   task automatic t_port;
      port_hi = 4'b1000;
      step(1);
      check("R4 change sets flag", {15'h0, reg_rdata[0]}, 16'h1);
      wr(8'h00);
      check("R4 mismatch keeps setting", {15'h0, reg_rdata[0]}, 16'h1);
      port_rd = 1'b1;
      step(1);
      port_rd = 1'b0;
      wr(8'h00);
      step(2);
      check("R4 snapshot matches, no set", {15'h0, reg_rdata[0]}, 16'h0);
      port_hi = 4'b1001;
      step(1);
      check("R4 second change", {15'h0, reg_rdata[0]}, 16'h1);
      port_rd = 1'b1;
      step(1);
      port_rd = 1'b0;
      wr(8'h00);
   endtask

   task automatic t_request;
      tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
      wr(8'h24);
      check("R5 no gie no req", {15'h0, irq_req}, 16'h0);
      wr(8'h84);
      check("R5 flag without enable no req", {15'h0, irq_req}, 16'h0);
      wr(8'hA4);
      check("R5 req all set", {15'h0, irq_req}, 16'h1);
   endtask

   task automatic t_ack;
      check("R7 idle vector", pc_vector, 16'h0000);
      irq_ack = 1'b1;
      step(1);
      irq_ack = 1'b0;
      check("R6 gie cleared, rest kept", {8'h0, reg_rdata}, 16'h0024);
      check("R7 pc_load", {15'h0, pc_load}, 16'h1);
      check("R7 vector", pc_vector, 16'h0004);
      check("R5 req drops", {15'h0, irq_req}, 16'h0);
      step(1);
      check("R7 pc_load one cycle", {15'h0, pc_load}, 16'h0);
      check("R7 vector back to 0", pc_vector, 16'h0000);
      irq_ret = 1'b1;
      step(1);
      irq_ret = 1'b0;
      check("R8 ret sets gie", {8'h0, reg_rdata}, 16'h00A4);
      irq_ret = 1'b1; irq_ack = 1'b1;
      step(1);
      irq_ret = 1'b0; irq_ack = 1'b0;
      check("R8 ack wins", {15'h0, reg_rdata[7]}, 16'h0);
   endtask

   task automatic t_wake;
      check("R10 awake no wake", {15'h0, wake}, 16'h0);
      in_sleep = 1'b1;
      step(1);
      check("R10 wake without gie", {15'h0, wake}, 16'h1);
      wr(8'h04);
      check("R10 no wake when disabled", {15'h0, wake}, 16'h0);
      in_sleep = 1'b0;
      wr(8'h00);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_timer();
      t_ext();
      t_port();
      t_request();
      t_ack();
      t_wake();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #50000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule